// File: doc/BRIEF.md
# Synchronous Microprocessor Bus Register Slave

This block answers register accesses from a synchronous 8-bit processor bus with an 18-bit address. Every bus input is sampled on the rising edge of the processor clock. A cycle opens when the active-low select is seen low. The block then captures the address and the direction line: high means read, low means write. It also loads a latency counter. Two further active-low strobes move the cycle on. The buffer-enable strobe qualifies a read and the write strobe qualifies a write. Once the latency has run out and the matching strobe is low, the block pulses an active-low acknowledge for one clock.

A small register bank sits behind the interface. Its lower half answers after a short latency and its upper half after a long one. Addresses outside the bank read as zero, ignore writes and are still acknowledged, so a master is never left waiting. The read data bus carries an output-enable flag that a pad ring would use to drive the shared data lines. The flag is high only while a read is open and the buffer-enable strobe is low.

Top module: `sync_bus_slave`

## Requirements
- R1: After reset the acknowledge is high, the output-enable is low and every register reads back as zero.
- R2: A read or write to a register in the lower half of the bank (index below NUM_REGS/2) is acknowledged on the rising edge FAST_LAT+2 edges after the edge that first samples select low, provided the strobe is already low. A read returns the stored byte.
- R3: An access to the upper half of the bank (index NUM_REGS/2 and above) is acknowledged SLOW_LAT+2 edges after the edge that first samples select low.
- R4: The acknowledge is low for exactly one clock and does not go low again while select stays low in the same cycle.
- R5: A write stores the data present on the edge that issues the acknowledge, once only. Changing the write data while the write strobe stays low after the acknowledge leaves the register unchanged.
- R6: An address whose bits above the bank index are non-zero reads as 0x00, does not change any register, and is acknowledged with the short latency.
- R7: The output-enable is high only while a read cycle is open and the buffer-enable strobe is low. It is low throughout write cycles and while idle.
- R8: If the matching strobe is still high when the latency runs out, the acknowledge waits and is issued on the first edge that samples the strobe low.
- R9: If select is sampled high before the acknowledge, the cycle is abandoned: no acknowledge is given and no register is written.
- R10: The address and direction are captured on the edge that first samples select low. Later changes to the address within the cycle change neither the latency nor the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (18) | Register address |
| wdata | input | DATA_W (8) | Write data from the master |
| rdata | output | DATA_W (8) | Read data toward the master |
| rdata_oe | output | 1 | High when the read data should drive the shared bus |
| cs_n | input | 1 | Active-low select; frames the cycle |
| rw | input | 1 | Direction: 1 read, 0 write |
| we_n | input | 1 | Active-low write strobe |
| dben_n | input | 1 | Active-low data-buffer enable, the read strobe |
| ta_n | output | 1 | Active-low transfer acknowledge, one clock wide |

## Verification
Two events can land on the same clock edge. One is the clean end of an access, where the counter expiring, the strobe arriving and the acknowledge being issued together commit the write. The other is the master pulling select away on that very edge. The bench tests this by releasing select at the exact edge where the acknowledge would otherwise come. It then checks that the acknowledge stays high and that a read-back shows the register untouched. A second test holds the strobe back past expiry and times the acknowledge to the strobe edge. Write data is also changed after the acknowledge, to show that the bank takes exactly one value per cycle.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_e;
endpackage

// File: rtl/slave_lat_map.sv
module slave_lat_map #(
    parameter int ADDR_W   = 18,
    parameter int NUM_REGS = 16,
    parameter int FAST_LAT = 3,
    parameter int SLOW_LAT = 7,
    parameter int REG_AW   = 4,
    parameter int CNT_W    = 3
) (
    input  logic [ADDR_W-1:0] map_addr,
    output logic              hit,
    output logic [REG_AW-1:0] idx,
    output logic [CNT_W-1:0]  lat
);
    localparam logic [REG_AW:0]  NREG = NUM_REGS[REG_AW:0];
    localparam logic [REG_AW:0]  HALF = NREG >> 1;
    localparam logic [CNT_W-1:0] FL   = FAST_LAT[CNT_W-1:0];
    localparam logic [CNT_W-1:0] SL   = SLOW_LAT[CNT_W-1:0];

    always_comb begin
        idx = map_addr[REG_AW-1:0];
        hit = (map_addr[ADDR_W-1:REG_AW] == '0) && ({1'b0, idx} < NREG);
        if (hit && ({1'b0, idx} >= HALF)) begin
            lat = SL;
        end else begin
            lat = FL;
        end
    end
endmodule

// File: rtl/slave_regbank.sv
module slave_regbank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int REG_AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] regs_d [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_idx == g[REG_AW-1:0])) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == i[REG_AW-1:0]) begin
                rd_data = regs_q[i];
            end
        end
    end
endmodule

// File: rtl/sync_bus_slave.sv
module sync_bus_slave
    import bus_slave_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int FAST_LAT = 3,
    parameter int SLOW_LAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              we_n,
    input  logic              dben_n,
    output logic              ta_n
);
    localparam int REG_AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CNT_W  = $clog2(SLOW_LAT + 1);

    typedef struct packed {
        bus_st_e           st;
        logic [ADDR_W-1:0] adr;
        logic              rd;
        logic [CNT_W-1:0]  cnt;
        logic              ta;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] map_addr;
    logic              hit;
    logic [REG_AW-1:0] idx;
    logic [CNT_W-1:0]  lat;
    logic              wr_en;
    logic [DATA_W-1:0] bank_rd;

    assign map_addr = (ctl_q.st == ST_IDLE) ? addr : ctl_q.adr;

    slave_lat_map #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS),
        .FAST_LAT(FAST_LAT),
        .SLOW_LAT(SLOW_LAT),
        .REG_AW  (REG_AW),
        .CNT_W   (CNT_W)
    ) u_map (
        .map_addr(map_addr),
        .hit     (hit),
        .idx     (idx),
        .lat     (lat)
    );

    slave_regbank #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W),
        .REG_AW  (REG_AW)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (idx),
        .wr_data(wdata),
        .rd_idx (idx),
        .rd_data(bank_rd)
    );

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.ta = 1'b1;
                if (!cs_n) begin
                    ctl_d.st  = ST_WAIT;
                    ctl_d.adr = addr;
                    ctl_d.rd  = rw;
                    ctl_d.cnt = lat;
                end
            end
            ST_WAIT: begin
                if (cs_n) begin
                    ctl_d.st = ST_IDLE;
                end else if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.rd ? !dben_n : !we_n) begin
                    ctl_d.st = ST_ACK;
                    ctl_d.ta = 1'b0;
                    wr_en    = !ctl_q.rd && hit;
                end
            end
            ST_ACK: begin
                ctl_d.ta = 1'b1;
                ctl_d.st = cs_n ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.ta  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ta_n     = ctl_q.ta;
    assign rdata    = hit ? bank_rd : '0;
    assign rdata_oe = (ctl_q.st != ST_IDLE) && ctl_q.rd && !dben_n;
endmodule

// File: rtl/sync_bus_slave_chk.sv
module sync_bus_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic dben_n,
    input logic ta_n,
    input logic rdata_oe,
    input logic wr_en
);
    // R4: acknowledge is a single-clock pulse
    assert_ack_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |=> ta_n);

    // R9: acknowledge only follows an edge that saw select low
    assert_ack_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ta_n) |-> $past(!cs_n));

    // R8: acknowledge only follows an edge that saw a strobe low
    assert_ack_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ta_n) |-> $past(!dben_n || !we_n));

    // R7: the data bus is only driven while the read strobe is low
    assert_oe_needs_dben_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !dben_n);

    // R5: a bank write always coincides with issuing the acknowledge
    assert_write_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ta_n);
endmodule

bind sync_bus_slave sync_bus_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .dben_n  (dben_n),
    .ta_n    (ta_n),
    .rdata_oe(rdata_oe),
    .wr_en   (wr_en)
);

// File: tb/tb_sync_bus_slave.sv
module tb_sync_bus_slave;
    localparam int CLK_P    = 10;
    localparam int FAST_LAT = 3;
    localparam int SLOW_LAT = 7;
    localparam int T_FAST   = FAST_LAT + 2;
    localparam int T_SLOW   = SLOW_LAT + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        cs_n = 1'b1;
    logic        rw = 1'b1;
    logic        we_n = 1'b1;
    logic        dben_n = 1'b1;
    logic        ta_n;

    int checks = 0;
    int errors = 0;

    sync_bus_slave #(.FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .cs_n(cs_n), .rw(rw), .we_n(we_n),
        .dben_n(dben_n), .ta_n(ta_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        cs_n = 1'b1; we_n = 1'b1; dben_n = 1'b1; rw = 1'b1;
        @(negedge clk);
    endtask

    // One full access with the strobe low from the start.
    task automatic bus_cycle(input logic rd, input logic [17:0] a, input logic [7:0] w,
                             output logic [7:0] r, output int lat, output logic oe);
        int n = 0;
        r = '0; oe = 1'b0; lat = 0;
        addr = a; rw = rd; wdata = w; cs_n = 1'b0;
        if (rd) dben_n = 1'b0; else we_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk); n++;
            if (!ta_n) begin
                lat = n; r = rdata; oe = rdata_oe;
                break;
            end
        end
        wdata = ~w;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check("R4 ack one clock", ta_n, 1);
        end
        idle_bus();
    endtask

    task automatic t_reset();
        logic [7:0] r; int l; logic oe;
        check("R1 ack idle", ta_n, 1);
        check("R1 oe idle", rdata_oe, 0);
        bus_cycle(1'b1, 18'd2, 8'h00, r, l, oe);
        check("R1 reg reset value", r, 8'h00);
        bus_cycle(1'b1, 18'd13, 8'h00, r, l, oe);
        check("R1 reg reset value hi", r, 8'h00);
    endtask

    task automatic t_fast();
        logic [7:0] r; int l; logic oe;
        bus_cycle(1'b0, 18'd3, 8'h5A, r, l, oe);
        check("R2 write latency", l, T_FAST);
        check("R7 oe low on write", oe, 0);
        bus_cycle(1'b1, 18'd3, 8'h00, r, l, oe);
        check("R2 read latency", l, T_FAST);
        check("R2 read data", r, 8'h5A);
        check("R5 single commit", r, 8'h5A);
        check("R7 oe high on read", oe, 1);
    endtask

    task automatic t_slow();
        logic [7:0] r; int l; logic oe;
        bus_cycle(1'b0, 18'd12, 8'hC3, r, l, oe);
        check("R3 write latency", l, T_SLOW);
        bus_cycle(1'b1, 18'd12, 8'h00, r, l, oe);
        check("R3 read latency", l, T_SLOW);
        check("R3 read data", r, 8'hC3);
        check("R5 single commit slow", r, 8'hC3);
    endtask

    task automatic t_oob();
        logic [7:0] r; int l; logic oe;
        bus_cycle(1'b0, 18'h00100, 8'hEE, r, l, oe);
        check("R6 write acked", l, T_FAST);
        bus_cycle(1'b1, 18'h00100, 8'h00, r, l, oe);
        check("R6 read acked", l, T_FAST);
        check("R6 reads zero", r, 8'h00);
        bus_cycle(1'b1, 18'd0, 8'h00, r, l, oe);
        check("R6 alias untouched", r, 8'h00);
    endtask

    task automatic t_late_strobe();
        int n = 0;
        addr = 18'd3; rw = 1'b1; cs_n = 1'b0; dben_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (!ta_n) n++;
        end
        check("R8 no ack without strobe", n, 0);
        check("R7 oe low without strobe", rdata_oe, 0);
        dben_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 ack right after strobe", ta_n, 0);
        check("R8 data", rdata, 8'h5A);
        idle_bus();
    endtask

    task automatic t_abort();
        int n = 0;
        logic [7:0] r; int l; logic oe;
        addr = 18'd5; rw = 1'b0; wdata = 8'h77; cs_n = 1'b0; we_n = 1'b0;
        for (int k = 0; k < T_FAST - 1; k++) begin
            @(posedge clk); @(negedge clk);
        end
        cs_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            if (!ta_n) n++;
        end
        check("R9 no ack after abort", n, 0);
        idle_bus();
        bus_cycle(1'b1, 18'd5, 8'h00, r, l, oe);
        check("R9 no write after abort", r, 8'h00);
    endtask

    task automatic t_addr_latch();
        int n = 0;
        int l = 0;
        logic [7:0] r = '0;
        addr = 18'd12; rw = 1'b1; cs_n = 1'b0; dben_n = 1'b0;
        @(posedge clk); @(negedge clk); n++;
        addr = 18'd3;
        for (int k = 0; k < 20; k++) begin
            if (!ta_n) begin l = n; r = rdata; break; end
            @(posedge clk); @(negedge clk); n++;
        end
        check("R10 latency from captured addr", l, T_SLOW);
        check("R10 data from captured addr", r, 8'hC3);
        idle_bus();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast();
        t_slow();
        t_oob();
        t_late_strobe();
        t_abort();
        t_addr_latch();
        check("R7 oe idle at end", rdata_oe, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule